// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block keeps the transfer state of one DMA channel. It holds the current source address, the current destination address and a 24-bit byte count, and it holds a reload copy of each. It updates them as the bus side reports finished read beats (data into the FIFO) and finished write beats (data out of the FIFO). It also works out how wide the next read beat may be, so that a read never asks for more bytes than remain.

Software loads the registers through a simple write port and then starts the channel. When a read beat brings the count to zero, the engine raises a count-to-zero event. If the reload enable is armed, all three working registers are loaded from their reload copies in the same cycle. The reload enable then disarms itself and a reload event fires, so a chain of buffers can run without a gap. If the reload enable is not armed, the channel drops its active status. Bus signalling and the FIFO itself sit outside this block.

Top module: `dma_xfer_engine`

## Requirements
- R1: While `rst` is high at a clock edge, the engine clears both addresses, the count, all three reload copies, the reload enable and the active status. After reset, `rd_width` reads 0 and both event outputs are low.
- R2: Beat width codes are 0 = byte (1 byte), 1 = halfword (2 bytes) and 2 = word (4 bytes), and code 3 is treated as a word. A read beat is accepted when `rd_beat` is high while `chan_active` is 1 and the count is nonzero. Each accepted read beat lowers the count by the byte size of `rd_width`.
- R3: On each accepted read beat, the source address rises by the byte size of `rd_width`, but only when `src_inc` is 1 and `periph_rx` is 0. Otherwise the source address stays constant.
- R4: While `chan_active` is 1, each `wr_beat` raises the destination address by the byte size of `wr_beat_width`, but only when `dst_inc` is 1 and `periph_tx` is 0. Otherwise the destination address stays constant.
- R5: `rd_width` is the smaller of two widths: the configured source width (with code 3 read as a word), and the widest beat that fits the remaining count. A count of 4 or more fits a word, a count of 2 or 3 fits a halfword, and a count of 1 or 0 fits a byte.
- R6: An accepted read beat that brings the count to zero raises `ctz_evt` for exactly one cycle, on the cycle after that beat.
- R7: If the reload enable is 1 at the zero-reaching beat, source, destination and count are loaded from their reload copies, and a reload overrides any increment in that cycle. The reload enable clears itself, `rld_evt` pulses together with `ctz_evt`, and the channel stays active.
- R8: If the reload enable is 0 at the zero-reaching beat, `chan_active` goes to 0 and the count stays at 0. After that, read and write beats change neither the addresses nor the count until the channel is enabled again.
- R9: `periph_rx` = 1 holds the source address constant whatever `src_inc` is. `periph_tx` = 1 holds the destination address constant whatever `dst_inc` is.
- R10: `burst_bytes` equals `burst_field` plus one, which gives a range of 1 to 32.
- R11: A write with `wr_en` = 1 goes to the register picked by `wr_sel`: 0 source address, 1 destination address, 2 count (low 24 bits), 3 source reload, 4 destination reload, 5 count reload, 6 reload enable (bit 0), 7 channel enable (bit 0). If a beat update and a write to the same working register land in the same cycle, the beat update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register selected for the write |
| wr_data | input | 32 | Write data |
| cfg_src_width | input | 2 | Configured source beat width code |
| src_inc | input | 1 | Source increment enable |
| dst_inc | input | 1 | Destination increment enable |
| periph_rx | input | 1 | Channel receives from a peripheral (source fixed) |
| periph_tx | input | 1 | Channel transmits to a peripheral (destination fixed) |
| burst_field | input | 5 | Burst size field |
| rd_beat | input | 1 | A read beat into the FIFO finished |
| wr_beat | input | 1 | A write beat out of the FIFO finished |
| wr_beat_width | input | 2 | Width code of the finished write beat |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| count | output | 24 | Remaining byte count |
| rd_width | output | 2 | Width code allowed for the next read beat |
| burst_bytes | output | 6 | Burst length in bytes |
| chan_active | output | 1 | Channel active status |
| ctz_evt | output | 1 | Count-to-zero event pulse |
| rld_evt | output | 1 | Reload event pulse |

## Verification
The assertions assume that the bus side reports a read beat at the width this block offered in `rd_width`, and not at some other width. They also assume that a write to the current address or count registers comes only with the checked conditions excluded, which is why each stability property leaves out cycles where `wr_en` is high. The directed stimulus always drives `rd_beat` against the `rd_width` that was just sampled. It changes the configuration inputs only between beats, and it makes exactly one deliberate collision between a count write and a read beat, to exercise the priority rule.

// File: rtl/dma_xe_pkg.sv
package dma_xe_pkg;

    typedef enum logic [1:0] {
        BEAT_BYTE = 2'd0,
        BEAT_HALF = 2'd1,
        BEAT_WORD = 2'd2,
        BEAT_RSVD = 2'd3
    } beat_w_e;

    typedef enum logic [2:0] {
        SEL_SRC     = 3'd0,
        SEL_DST     = 3'd1,
        SEL_CNT     = 3'd2,
        SEL_SRC_RLD = 3'd3,
        SEL_DST_RLD = 3'd4,
        SEL_CNT_RLD = 3'd5,
        SEL_RLD_EN  = 3'd6,
        SEL_CH_EN   = 3'd7
    } wsel_e;

    typedef struct packed {
        logic       fire;
        logic       last;
        logic [2:0] step;
    } rd_step_t;

    function automatic logic [2:0] beat_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] cap_width(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

endpackage

// File: rtl/dma_xe_width_sel.sv
module dma_xe_width_sel
    import dma_xe_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic [CNT_W-1:0] count,
    input  logic [1:0]       cfg_width,
    output logic [1:0]       rd_width
);
    logic [1:0] cap;
    logic [1:0] fit;

    always_comb begin
        cap = cap_width(cfg_width);
        if (count >= CNT_W'(4))
            fit = BEAT_WORD;
        else if (count >= CNT_W'(2))
            fit = BEAT_HALF;
        else
            fit = BEAT_BYTE;
        rd_width = (fit < cap) ? fit : cap;
    end
endmodule

// File: rtl/dma_xe_addr_reg.sv
module dma_xe_addr_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_cur,
    input  logic              wr_rld,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              step_en,
    input  logic [2:0]        step_bytes,
    input  logic              reload,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] rld_val;
    logic [ADDR_W-1:0] step_ext;

    assign step_ext = {{(ADDR_W-3){1'b0}}, step_bytes};

    always_ff @(posedge clk) begin
        if (rst) begin
            addr    <= '0;
            rld_val <= '0;
        end else begin
            if (reload)
                addr <= rld_val;
            else if (step_en)
                addr <= addr + step_ext;
            else if (wr_cur)
                addr <= wr_data;
            if (wr_rld)
                rld_val <= wr_data;
        end
    end
endmodule

// File: rtl/dma_xe_count.sv
module dma_xe_count
    import dma_xe_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_beat,
    input  logic [1:0]       rd_width,
    output logic [CNT_W-1:0] count,
    output logic             chan_active,
    output logic             rd_fire,
    output logic             reload_now,
    output logic             ctz_evt,
    output logic             rld_evt
);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt_rld;
    logic             rld_armed;
    rd_step_t         rs;
    logic [CNT_W-1:0] step_ext;
    wsel_e            sel;

    always_comb begin
        sel      = wsel_e'(wr_sel);
        rs.step  = beat_bytes(rd_width);
        step_ext = {{(CNT_W-3){1'b0}}, rs.step};
        rs.fire  = rd_beat && chan_active && (count != ZERO);
        rs.last  = rs.fire && (count == step_ext);
    end

    assign rd_fire    = rs.fire;
    assign reload_now = rs.last && rld_armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            count       <= '0;
            cnt_rld     <= '0;
            rld_armed   <= 1'b0;
            chan_active <= 1'b0;
            ctz_evt     <= 1'b0;
            rld_evt     <= 1'b0;
        end else begin
            ctz_evt <= rs.last;
            rld_evt <= rs.last && rld_armed;

            if (rs.last && rld_armed)
                count <= cnt_rld;
            else if (rs.fire)
                count <= count - step_ext;
            else if (wr_en && sel == SEL_CNT)
                count <= wr_data;

            if (wr_en && sel == SEL_CNT_RLD)
                cnt_rld <= wr_data;

            if (rs.last && rld_armed)
                rld_armed <= 1'b0;
            else if (wr_en && sel == SEL_RLD_EN)
                rld_armed <= wr_data[0];

            if (rs.last && !rld_armed)
                chan_active <= 1'b0;
            else if (wr_en && sel == SEL_CH_EN)
                chan_active <= wr_data[0];
        end
    end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_xe_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 24,
    parameter int BURST_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [ADDR_W-1:0]  wr_data,
    input  logic [1:0]         cfg_src_width,
    input  logic               src_inc,
    input  logic               dst_inc,
    input  logic               periph_rx,
    input  logic               periph_tx,
    input  logic [BURST_W-1:0] burst_field,
    input  logic               rd_beat,
    input  logic               wr_beat,
    input  logic [1:0]         wr_beat_width,
    output logic [ADDR_W-1:0]  src_addr,
    output logic [ADDR_W-1:0]  dst_addr,
    output logic [CNT_W-1:0]   count,
    output logic [1:0]         rd_width,
    output logic [BURST_W:0]   burst_bytes,
    output logic               chan_active,
    output logic               ctz_evt,
    output logic               rld_evt
);
    logic rd_fire;
    logic reload_now;
    logic src_step_en;
    logic dst_step_en;

    assign src_step_en = rd_fire && src_inc && !periph_rx;
    assign dst_step_en = wr_beat && chan_active && dst_inc && !periph_tx;
    assign burst_bytes = {1'b0, burst_field} + 1'b1;

    dma_xe_width_sel #(.CNT_W(CNT_W)) u_width (
        .count     (count),
        .cfg_width (cfg_src_width),
        .rd_width  (rd_width)
    );

    dma_xe_count #(.CNT_W(CNT_W)) u_count (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data[CNT_W-1:0]),
        .rd_beat     (rd_beat),
        .rd_width    (rd_width),
        .count       (count),
        .chan_active (chan_active),
        .rd_fire     (rd_fire),
        .reload_now  (reload_now),
        .ctz_evt     (ctz_evt),
        .rld_evt     (rld_evt)
    );

    dma_xe_addr_reg #(.ADDR_W(ADDR_W)) u_src (
        .clk        (clk),
        .rst        (rst),
        .wr_cur     (wr_en && wr_sel == SEL_SRC),
        .wr_rld     (wr_en && wr_sel == SEL_SRC_RLD),
        .wr_data    (wr_data),
        .step_en    (src_step_en),
        .step_bytes (beat_bytes(rd_width)),
        .reload     (reload_now),
        .addr       (src_addr)
    );

    dma_xe_addr_reg #(.ADDR_W(ADDR_W)) u_dst (
        .clk        (clk),
        .rst        (rst),
        .wr_cur     (wr_en && wr_sel == SEL_DST),
        .wr_rld     (wr_en && wr_sel == SEL_DST_RLD),
        .wr_data    (wr_data),
        .step_en    (dst_step_en),
        .step_bytes (beat_bytes(wr_beat_width)),
        .reload     (reload_now),
        .addr       (dst_addr)
    );
endmodule

// File: rtl/dma_xe_checker.sv
module dma_xe_checker
    import dma_xe_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        cfg_src_width,
    input logic              src_inc,
    input logic              periph_rx,
    input logic              rd_beat,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [CNT_W-1:0]  count,
    input logic [1:0]        rd_width,
    input logic              chan_active,
    input logic              ctz_evt,
    input logic              rld_evt
);
    logic [CNT_W-1:0] step_now;
    assign step_now = {{(CNT_W-3){1'b0}}, beat_bytes(rd_width)};

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_beat && chan_active && count > step_now) |=> (count == $past(count) - $past(step_now)));

    assert_src_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!src_inc && !wr_en) |=> ($stable(src_addr) || rld_evt));

    assert_width_fit_R5: assert property (@(posedge clk) disable iff (rst)
        (count != '0) |-> (step_now <= count && rd_width <= cap_width(cfg_src_width)));

    assert_reload_pair_R7: assert property (@(posedge clk) disable iff (rst)
        rld_evt |-> ctz_evt);

    assert_stop_state_R8: assert property (@(posedge clk) disable iff (rst)
        (ctz_evt && !rld_evt) |-> (!chan_active && count == '0));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!chan_active && !wr_en) |=> ($stable(count) && $stable(src_addr) && $stable(dst_addr)));

    assert_rx_fixed_R9: assert property (@(posedge clk) disable iff (rst)
        (periph_rx && !wr_en) |=> ($stable(src_addr) || rld_evt));
endmodule

bind dma_xfer_engine dma_xe_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_xe_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .cfg_src_width (cfg_src_width),
    .src_inc       (src_inc),
    .periph_rx     (periph_rx),
    .rd_beat       (rd_beat),
    .src_addr      (src_addr),
    .dst_addr      (dst_addr),
    .count         (count),
    .rd_width      (rd_width),
    .chan_active   (chan_active),
    .ctz_evt       (ctz_evt),
    .rld_evt       (rld_evt)
);

// File: tb/dma_xfer_engine_bench.sv
module dma_xfer_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  cfg_src_width = 2'd2;
    logic        src_inc = 1'b1;
    logic        dst_inc = 1'b1;
    logic        periph_rx = 1'b0;
    logic        periph_tx = 1'b0;
    logic [4:0]  burst_field = '0;
    logic        rd_beat = 1'b0;
    logic        wr_beat = 1'b0;
    logic [1:0]  wr_beat_width = '0;
    logic [31:0] src_addr;
    logic [31:0] dst_addr;
    logic [23:0] count;
    logic [1:0]  rd_width;
    logic [5:0]  burst_bytes;
    logic        chan_active;
    logic        ctz_evt;
    logic        rld_evt;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dma_xfer_engine u_dma_xfer_engine (
        .clk, .rst, .wr_en, .wr_sel, .wr_data, .cfg_src_width, .src_inc, .dst_inc,
        .periph_rx, .periph_tx, .burst_field, .rd_beat, .wr_beat, .wr_beat_width,
        .src_addr, .dst_addr, .count, .rd_width, .burst_bytes, .chan_active,
        .ctz_evt, .rld_evt
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rbeat();
        @(negedge clk);
        rd_beat = 1'b1;
        @(negedge clk);
        rd_beat = 1'b0;
    endtask

    task automatic wbeat(input logic [1:0] w);
        @(negedge clk);
        wr_beat = 1'b1; wr_beat_width = w;
        @(negedge clk);
        wr_beat = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 src", src_addr, 0);
        chk("R1 dst", dst_addr, 0);
        chk("R1 count", {8'd0, count}, 0);
        chk("R1 active", {31'd0, chan_active}, 0);
        chk("R1 width", {30'd0, rd_width}, 0);
        chk("R1 ctz", {31'd0, ctz_evt}, 0);
    endtask

    task automatic t_main();
        cfg_src_width = 2'd2; src_inc = 1; dst_inc = 1;
        wr(0, 32'h1000); wr(1, 32'h2000); wr(2, 10); wr(7, 1);
        chk("R5 word fits", {30'd0, rd_width}, 2);
        wbeat(2'd1);
        chk("R4 dst half step", dst_addr, 32'h2002);
        wbeat(2'd3);
        chk("R2 code3 as word", dst_addr, 32'h2006);
        rbeat();
        chk("R2 count step", {8'd0, count}, 6);
        chk("R3 src step", src_addr, 32'h1004);
        rbeat();
        chk("R2 count 2", {8'd0, count}, 2);
        chk("R5 cut to half", {30'd0, rd_width}, 1);
        rbeat();
        chk("R3 src half", src_addr, 32'h100A);
        chk("R6 ctz pulse", {31'd0, ctz_evt}, 1);
        chk("R8 inactive", {31'd0, chan_active}, 0);
        chk("R8 count zero", {8'd0, count}, 0);
        @(negedge clk);
        chk("R6 ctz one cycle", {31'd0, ctz_evt}, 0);
        rbeat();
        chk("R8 src ignored", src_addr, 32'h100A);
        wbeat(2'd2);
        chk("R8 dst ignored", dst_addr, 32'h2006);
    endtask

    task automatic t_width();
        wr(2, 10);
        cfg_src_width = 2'd0; @(negedge clk);
        chk("R5 cfg byte", {30'd0, rd_width}, 0);
        cfg_src_width = 2'd3; wr(2, 3);
        chk("R5 count3 half", {30'd0, rd_width}, 1);
        wr(2, 1);
        chk("R5 count1 byte", {30'd0, rd_width}, 0);
        cfg_src_width = 2'd2; wr(2, 0);
        chk("R5 count0 byte", {30'd0, rd_width}, 0);
    endtask

    task automatic t_reload();
        cfg_src_width = 2'd2;
        wr(0, 32'h100); wr(1, 32'h200); wr(2, 4);
        wr(3, 32'h300); wr(4, 32'h400); wr(5, 8); wr(6, 1); wr(7, 1);
        rbeat();
        chk("R7 src reload", src_addr, 32'h300);
        chk("R7 dst reload", dst_addr, 32'h400);
        chk("R7 count reload", {8'd0, count}, 8);
        chk("R7 rld pulse", {31'd0, rld_evt}, 1);
        chk("R6 ctz with reload", {31'd0, ctz_evt}, 1);
        chk("R7 still active", {31'd0, chan_active}, 1);
        rbeat(); rbeat();
        chk("R7 second ctz", {31'd0, ctz_evt}, 1);
        chk("R7 rld disarmed", {31'd0, rld_evt}, 0);
        chk("R7 stop after", {31'd0, chan_active}, 0);
        chk("R3 src after chain", src_addr, 32'h308);
    endtask

    task automatic t_periph();
        wr(0, 32'h500); wr(1, 32'h600); wr(2, 16); wr(7, 1);
        periph_rx = 1; src_inc = 1;
        rbeat();
        chk("R9 rx src fixed", src_addr, 32'h500);
        chk("R2 count rx", {8'd0, count}, 12);
        periph_rx = 0; periph_tx = 1;
        wbeat(2'd2);
        chk("R9 tx dst fixed", dst_addr, 32'h600);
        periph_tx = 0; dst_inc = 0;
        wbeat(2'd2);
        chk("R4 dst_inc off", dst_addr, 32'h600);
        dst_inc = 1; src_inc = 0;
        rbeat();
        chk("R3 src_inc off", src_addr, 32'h500);
        src_inc = 1;
    endtask

    task automatic t_collide();
        wr(2, 8);
        @(negedge clk);
        wr_en = 1; wr_sel = 3'd2; wr_data = 100; rd_beat = 1;
        @(negedge clk);
        wr_en = 0; rd_beat = 0;
        chk("R11 beat wins", {8'd0, count}, 4);
        wr(7, 0);
        chk("R11 enable write", {31'd0, chan_active}, 0);
    endtask

    task automatic t_burst();
        burst_field = 5'd0; @(negedge clk);
        chk("R10 burst min", {26'd0, burst_bytes}, 1);
        burst_field = 5'd31; @(negedge clk);
        chk("R10 burst max", {26'd0, burst_bytes}, 32);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_main();
        t_width();
        t_reload();
        t_periph();
        t_collide();
        t_burst();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule